// File: doc/BRIEF.md
# Logic Probe State Indicator

The block sits behind two threshold comparators that watch a probed node: one reports that the node is above the high threshold, the other that it is below the low threshold. Both results are sampled on a fast clock. From them the block produces a three-way lamp command: bright for a valid high, off for a valid low, and dim for a node that sits between the thresholds. An input that claims to be both high and low at once is not a legal combination, so it is also shown as dim.

Short activity on the node is made visible. A change between the two valid levels counts as a pulse. A pulse starts a stretch window of `STRETCH_CYC` clock cycles. During that window the lamp shows the level opposite to the one the node rested at before the pulse. If a second pulse leaves that resting level again inside the window, the block treats the activity as a pulse train. The lamp then flashes bright and off, changing state every `BLINK_HALF_CYC` cycles, until the window runs out.

A memory flag records that a pulse has been seen. It stays set until the reset input clears it. With a sample clock of 100 MHz or faster, a 10 ns pulse lands in at least one sample. The default parameters give a 0.1 s stretch and a 10 Hz flash rate at 100 MHz.

Top module: `probe_indicator`

## Requirements
- R1: With only the above-high input set, and no stretch active, `lamp_o` is 2'b10 (bright).
- R2: With only the below-low input set, and no stretch active, `lamp_o` is 2'b00 (off).
- R3: With neither input set, or both inputs set, and no stretch active, `lamp_o` is 2'b01 (dim). `lamp_o` never takes the value 2'b11.
- R4: A change from a valid low to a valid high and back (a high pulse on a low node) keeps `lamp_o` at 2'b10 for about `STRETCH_CYC` cycles. After that the lamp returns to the static level.
- R5: A low pulse on a high node keeps `lamp_o` at 2'b00 for about `STRETCH_CYC` cycles. After that the lamp returns to bright.
- R6: A move into or out of the between-thresholds level is not a pulse. It starts no stretch and does not set `mem_o`.
- R7: When a second pulse leaves the resting level while a stretch is active, the lamp flashes. It starts bright, toggles between 2'b10 and 2'b00 every `BLINK_HALF_CYC` cycles and is never dim. When the pulses stop, the flashing ends once the stretch window runs out.
- R8: A pulse sets `mem_o` one cycle after the pulse is detected. The flag stays set after the stretch ends.
- R9: Asserting `mem_clr_i` in a cycle with no pulse clears `mem_o`.
- R10: If `mem_clr_i` and a pulse occur in the same cycle, `mem_o` is set.
- R11: While `rst_ni` is low and after reset, `lamp_o` is 2'b01 and `mem_o` is 0, until a valid level has been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_i | input | 1 | Node is above the high threshold |
| lo_i | input | 1 | Node is below the low threshold |
| mem_clr_i | input | 1 | Clears the pulse memory flag |
| lamp_o | output | 2 | Lamp command: 00 off, 01 dim, 10 bright |
| mem_o | output | 1 | Pulse memory flag |

## Verification
The checks assume that the threshold bits are already synchronous to `clk_i` and that each level lasts at least one sample. The bench drives them only on the falling clock edge, so every level spans whole cycles. The checks also assume that `mem_clr_i` is a level held for whole cycles, and the stimulus keeps it that way. The illegal both-set combination is driven only as a static level, because the block never counts it as part of a pulse.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef enum logic [1:0] {
    LV_LO  = 2'd0,
    LV_HI  = 2'd1,
    LV_BAD = 2'd2
  } lvl_e;

  localparam logic [1:0] LAMP_OFF    = 2'b00;
  localparam logic [1:0] LAMP_DIM    = 2'b01;
  localparam logic [1:0] LAMP_BRIGHT = 2'b10;
endpackage

// File: rtl/probe_lvl_sync.sv
module probe_lvl_sync
  import probe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic lo_i,
  output lvl_e lvl_o,
  output lvl_e prv_o
);
  lvl_e lvl_d, lvl_q, prv_q;

  always_comb begin
    unique case ({hi_i, lo_i})
      2'b10:   lvl_d = LV_HI;
      2'b01:   lvl_d = LV_LO;
      default: lvl_d = LV_BAD; // between thresholds, or illegal both-set
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LV_BAD;
      prv_q <= LV_BAD;
    end else begin
      lvl_q <= lvl_d;
      prv_q <= lvl_q;
    end
  end

  assign lvl_o = lvl_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/probe_stretch.sv
module probe_stretch
  import probe_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_e lvl_i,
  input  lvl_e prv_i,
  output logic pulse_o,
  output logic active_o,
  output logic train_o,
  output lvl_e base_o
);
  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          train_q;
  lvl_e          base_q;
  logic          pulse, active;

  assign pulse  = (lvl_i != prv_i) && (lvl_i != LV_BAD) && (prv_i != LV_BAD);
  assign active = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      train_q <= 1'b0;
      base_q  <= LV_LO;
    end else if (pulse) begin
      cnt_q <= LOAD;
      if (!active) base_q <= prv_i;
      // leaving the resting level again inside the window means a train
      if (active && (prv_i == base_q)) train_q <= 1'b1;
    end else if (active) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) train_q <= 1'b0;
    end
  end

  assign pulse_o  = pulse;
  assign active_o = active;
  assign train_o  = train_q;
  assign base_o   = base_q;
endmodule

// File: rtl/probe_blinker.sv
module probe_blinker #(
  parameter int unsigned BLINK_HALF_CYC = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic on_o
);
  localparam int unsigned BW = (BLINK_HALF_CYC > 1) ? $clog2(BLINK_HALF_CYC) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLINK_HALF_CYC - 1);

  logic [BW-1:0] cnt_q;
  logic          on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_q  <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      on_q  <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      on_q  <= ~on_q;
    end else begin
      cnt_q <= cnt_q + BW'(1);
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/probe_mem.sv
module probe_mem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic mem_o
);
  logic mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mem_q <= 1'b0;
    else if (set_i) mem_q <= 1'b1; // set wins over clear
    else if (clr_i) mem_q <= 1'b0;
  end

  assign mem_o = mem_q;
endmodule

// File: rtl/probe_indicator.sv
module probe_indicator
  import probe_pkg::*;
#(
  parameter int unsigned STRETCH_CYC    = 10_000_000,
  parameter int unsigned BLINK_HALF_CYC = 5_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hi_i,
  input  logic       lo_i,
  input  logic       mem_clr_i,
  output logic [1:0] lamp_o,
  output logic       mem_o
);
  lvl_e lvl_w, prv_w, base_w;
  logic pulse_w, stretch_w, train_w, blink_on_w;

  probe_lvl_sync i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hi_i  (hi_i),
    .lo_i  (lo_i),
    .lvl_o (lvl_w),
    .prv_o (prv_w)
  );

  probe_stretch #(.STRETCH_CYC(STRETCH_CYC)) i_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl_w),
    .prv_i   (prv_w),
    .pulse_o (pulse_w),
    .active_o(stretch_w),
    .train_o (train_w),
    .base_o  (base_w)
  );

  probe_blinker #(.BLINK_HALF_CYC(BLINK_HALF_CYC)) i_blink (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (train_w),
    .on_o  (blink_on_w)
  );

  probe_mem i_mem (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (pulse_w),
    .clr_i (mem_clr_i),
    .mem_o (mem_o)
  );

  always_comb begin
    if (train_w)
      lamp_o = blink_on_w ? LAMP_BRIGHT : LAMP_OFF;
    else if (stretch_w)
      lamp_o = (base_w == LV_LO) ? LAMP_BRIGHT : LAMP_OFF;
    else begin
      unique case (lvl_w)
        LV_HI:   lamp_o = LAMP_BRIGHT;
        LV_LO:   lamp_o = LAMP_OFF;
        default: lamp_o = LAMP_DIM;
      endcase
    end
  end
endmodule

// File: rtl/probe_indicator_chk.sv
module probe_indicator_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_clr_i,
  input logic [1:0] lamp_o,
  input logic       mem_o,
  input logic       pulse_i,
  input logic       stretch_i,
  input logic       train_i
);
  // R3
  lamp_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lamp_o != 2'b11);

  // R7
  train_not_dim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_i |-> lamp_o != 2'b01);

  // R4
  pulse_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> stretch_i);

  // R10
  pulse_sets_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> mem_o);

  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_o && !mem_clr_i) |=> mem_o);

  // R9
  mem_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_o) |-> $past(mem_clr_i));
endmodule

bind probe_indicator probe_indicator_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_clr_i(mem_clr_i),
  .lamp_o   (lamp_o),
  .mem_o    (mem_o),
  .pulse_i  (pulse_w),
  .stretch_i(stretch_w),
  .train_i  (train_w)
);

// File: tb/test_probe_indicator.sv
module test_probe_indicator;
  localparam int unsigned STRETCH = 20;
  localparam int unsigned HALF    = 4;
  localparam logic [1:0] OFF = 2'b00, DIM = 2'b01, BRT = 2'b10;

  // {hi, lo, expected lamp}
  localparam logic [3:0] VEC [6] = '{
    4'b10_10, 4'b01_00, 4'b00_01, 4'b11_01, 4'b10_10, 4'b00_01
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic hi = 1'b0, lo = 1'b0, clr = 1'b0;
  logic [1:0] lamp;
  logic mem;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  probe_indicator #(.STRETCH_CYC(STRETCH), .BLINK_HALF_CYC(HALF)) i_probe_indicator (
    .clk_i(clk), .rst_ni(rst_n), .hi_i(hi), .lo_i(lo),
    .mem_clr_i(clr), .lamp_o(lamp), .mem_o(mem)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_lvl(input logic h, input logic l);
    @(negedge clk);
    hi = h; lo = l;
  endtask

  task automatic clear_mem();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #200_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int toggles, dims, brights, offs;
    logic [1:0] prev;
    wait_n(3);
    check("R11 reset lamp", lamp, DIM);
    check("R11 reset mem", {1'b0, mem}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    wait_n(2);
    check("R11 after reset lamp", lamp, DIM);

    // static level table
    for (int k = 0; k < 6; k++) begin
      set_lvl(VEC[k][3], VEC[k][2]);
      wait_n(STRETCH + 10);
      check($sformatf("R1/R2/R3 vec %0d", k), lamp, VEC[k][1:0]);
    end

    // R2 static low, then R6: excursions through bad level
    set_lvl(1'b0, 1'b1); wait_n(STRETCH + 10);
    clear_mem(); wait_n(2);
    check("R9 mem cleared", {1'b0, mem}, 2'b00);
    set_lvl(1'b0, 1'b0); wait_n(3);
    check("R6 bad level dim", lamp, DIM);
    set_lvl(1'b0, 1'b1); wait_n(3);
    check("R6 no stretch after bad", lamp, OFF);
    check("R6 no mem after bad", {1'b0, mem}, 2'b00);

    // R4 single high pulse on low node
    set_lvl(1'b1, 1'b0); set_lvl(1'b0, 1'b1);
    wait_n(6);
    check("R4 stretched bright", lamp, BRT);
    check("R8 mem set", {1'b0, mem}, 2'b01);
    wait_n(STRETCH + 10);
    check("R4 back to off", lamp, OFF);
    check("R8 mem held", {1'b0, mem}, 2'b01);

    // R9 clear
    clear_mem(); wait_n(1);
    check("R9 clear", {1'b0, mem}, 2'b00);

    // R5 single low pulse on high node
    set_lvl(1'b1, 1'b0); wait_n(STRETCH + 10);
    check("R1 static high", lamp, BRT);
    set_lvl(1'b0, 1'b1); set_lvl(1'b1, 1'b0);
    wait_n(6);
    check("R5 stretched off", lamp, OFF);
    wait_n(STRETCH + 10);
    check("R5 back to bright", lamp, BRT);

    // R10 clear and pulse in same cycle
    set_lvl(1'b0, 1'b1); wait_n(STRETCH + 10);
    clear_mem(); wait_n(1);
    check("R10 precondition", {1'b0, mem}, 2'b00);
    set_lvl(1'b1, 1'b0);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R10 pulse wins", {1'b0, mem}, 2'b01);

    // R7 pulse train on low node
    set_lvl(1'b0, 1'b1); wait_n(STRETCH + 10);
    toggles = 0; dims = 0; brights = 0; offs = 0; prev = 2'bxx;
    for (int it = 0; it < 10; it++) begin
      for (int s = 0; s < 6; s++) begin
        @(negedge clk);
        if (s == 0) begin hi = 1'b1; lo = 1'b0; end
        else if (s == 1) begin hi = 1'b0; lo = 1'b1; end
        if (it >= 2) begin
          if (lamp == DIM) dims++;
          if (lamp == BRT) brights++;
          if (lamp == OFF) offs++;
          if (prev !== 2'bxx && lamp != prev) toggles++;
          prev = lamp;
        end
      end
    end
    check("R7 never dim", dims[1:0], 2'b00);
    check("R7 flashing", {1'b0, (toggles >= 8 && brights > 0 && offs > 0)}, 2'b01);
    wait_n(STRETCH + 10);
    check("R7 flashing ends", lamp, OFF);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule